// File: doc/BRIEF.md
# Double-Buffered DAC Command Register

This block sits behind a serial receiver that assembles 24-bit command words for a voltage-output converter. Each time the receiver presents a complete word with a single-cycle valid strobe, the block reads a 4-bit command from the top of the word and acts on two registers. The staging register holds a code that is not yet shown. The output register drives the converter code. A power-down flag tells the analog side to shut off.

Writes fill the staging register and leave the output unchanged. Updates move the staged code to the output and wake the converter. A combined command loads the new code into both registers at once. A power-down command only raises the flag and keeps both codes. The code resolution (12, 10 or 8 bits) and the code both registers hold after reset (zero-scale or mid-scale) are build parameters.

Top module: `dac_cmd_regs`

## Requirements
- R1: While reset is asserted, on the clock edge both registers take zero-scale (RESET_MID=0) or mid-scale, 1 << (RES_BITS-1) (RESET_MID=1), and the powered-down flag is cleared.
- R2: The command is bits 23:20 of the word. Bits 19:16 have no effect.
- R3: The code is bits 15:(16-RES_BITS), MSB first. The low 16-RES_BITS bits have no effect.
- R4: Command 4'b0000 loads the code into the staging register and leaves `dac_code` unchanged.
- R5: Command 4'b0001 copies the staging register into the output register.
- R6: Command 4'b0011 loads the code from that same word into both registers, so `dac_code` shows the new code and not the old staged value.
- R7: Commands 4'b0001 and 4'b0011 clear the powered-down flag.
- R8: Command 4'b0100 sets the powered-down flag and keeps the contents of both registers.
- R9: Every other command value leaves both registers and the flag unchanged.
- R10: When `word_valid` is low, both registers and the flag hold their values.
- R11: A command's effect appears on the outputs after the clock edge that samples the strobe. This is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | Single-cycle strobe: `word_in` is a complete command word |
| word_in | input | 24 | Command word: command in 23:20, code left-justified in 15:0 |
| dac_code | output | RES_BITS | Code currently driving the converter |
| powered_down | output | 1 | High while the converter is commanded off |

## Verification
The assertions assume that `word_valid` and `word_in` are driven to known values in every cycle after reset. They also assume that reset is held for at least one clock edge before it is released. The bench changes inputs only on the falling edge and holds reset low over the first edges. Random words draw the command nibble from the full 16-value range, so that undefined codes and the defined ones are mixed. The random words also vary the ignored bits and the strobe density.

// File: rtl/dac_cmd_pkg.sv
// Shared command encodings and decoded-action bundle for the DAC command register.
// Assumes the command nibble sits in bits 23:20 of a 24-bit word.
package dac_cmd_pkg;

    localparam int WORD_W = 24;
    localparam int FIELD_W = 16;

    typedef enum logic [3:0] {
        CMD_STAGE      = 4'b0000,
        CMD_COMMIT     = 4'b0001,
        CMD_STAGE_COMMIT = 4'b0011,
        CMD_SLEEP      = 4'b0100
    } dac_cmd_e;

    typedef struct packed {
        logic load_stage;   // capture new code into staging register
        logic load_out;     // load output register
        logic out_from_new; // output register takes new code instead of staged
        logic sleep;        // raise powered-down flag
        logic wake;         // clear powered-down flag
    } dac_act_t;

endpackage

// File: rtl/dac_cmd_decode.sv
// Turns a strobed command nibble into a set of register actions.
// Assumes the strobe lasts one cycle; with no strobe every action is low.
module dac_cmd_decode
    import dac_cmd_pkg::*;
(
    input  logic       strobe,
    input  logic [3:0] cmd,
    output dac_act_t   act
);

    // Map the command to actions; unknown codes produce no action.
    always_comb begin
        act = '0;
        if (strobe) begin
            case (cmd)
                CMD_STAGE: begin
                    act.load_stage = 1'b1;
                end
                CMD_COMMIT: begin
                    act.load_out = 1'b1;
                    act.wake     = 1'b1;
                end
                CMD_STAGE_COMMIT: begin
                    act.load_stage   = 1'b1;
                    act.load_out     = 1'b1;
                    act.out_from_new = 1'b1;
                    act.wake         = 1'b1;
                end
                CMD_SLEEP: begin
                    act.sleep = 1'b1;
                end
                default: act = '0;
            endcase
        end
    end

endmodule

// File: rtl/dac_code_field.sv
// Extracts the left-justified code from the 16-bit data field.
// Assumes RES_BITS is at most 16; bits below the code are discarded.
module dac_code_field #(
    parameter int RES_BITS = 12
) (
    input  logic [15:0]         field,
    output logic [RES_BITS-1:0] code
);

    localparam int PAD_W = 16 - RES_BITS;

    // Take the top RES_BITS bits of the field.
    always_comb begin
        code = field[15 -: RES_BITS];
    end

endmodule

// File: rtl/dac_reg_pair.sv
// Staging and output code registers plus the powered-down flag.
// Assumes at most one of sleep/wake is high in a cycle (the decoder guarantees it).
module dac_reg_pair
    import dac_cmd_pkg::*;
#(
    parameter int RES_BITS  = 12,
    parameter bit RESET_MID = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  dac_act_t            act,
    input  logic [RES_BITS-1:0] new_code,
    output logic [RES_BITS-1:0] out_code,
    output logic                sleeping
);

    logic [RES_BITS-1:0] rst_code;
    logic [RES_BITS-1:0] stage_q;
    logic [RES_BITS-1:0] out_next;

    // Pick the power-on code from the build parameter.
    generate
        if (RESET_MID) begin : g_rst_mid
            assign rst_code = {1'b1, {(RES_BITS-1){1'b0}}};
        end else begin : g_rst_zero
            assign rst_code = '0;
        end
    endgenerate

    // Choose what the output register loads: new word code or staged code.
    always_comb begin
        out_next = act.out_from_new ? new_code : stage_q;
    end

    // Staging register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= rst_code;
        end else if (act.load_stage) begin
            stage_q <= new_code;
        end
    end

    // Output register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_code <= rst_code;
        end else if (act.load_out) begin
            out_code <= out_next;
        end
    end

    // Powered-down flag: set by sleep, cleared by any commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleeping <= 1'b0;
        end else if (act.sleep) begin
            sleeping <= 1'b1;
        end else if (act.wake) begin
            sleeping <= 1'b0;
        end
    end

endmodule

// File: rtl/dac_cmd_regs.sv
// Top: decodes strobed 24-bit command words and drives the DAC code and power-down flag.
// Assumes word_valid is a single-cycle strobe from an upstream serial receiver.
module dac_cmd_regs
    import dac_cmd_pkg::*;
#(
    parameter int RES_BITS  = 12,
    parameter bit RESET_MID = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_valid,
    input  logic [23:0]         word_in,
    output logic [RES_BITS-1:0] dac_code,
    output logic                powered_down
);

    dac_act_t            act;
    logic [RES_BITS-1:0] new_code;

    dac_cmd_decode u_decode (
        .strobe (word_valid),
        .cmd    (word_in[23:20]),
        .act    (act)
    );

    dac_code_field #(.RES_BITS(RES_BITS)) u_field (
        .field (word_in[15:0]),
        .code  (new_code)
    );

    dac_reg_pair #(.RES_BITS(RES_BITS), .RESET_MID(RESET_MID)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .new_code (new_code),
        .out_code (dac_code),
        .sleeping (powered_down)
    );

endmodule

// File: rtl/dac_cmd_regs_chk.sv
// Port-level property checker for dac_cmd_regs, attached with bind.
// Assumes inputs are known after reset and reset spans at least one edge.
module dac_cmd_regs_chk #(
    parameter int RES_BITS  = 12,
    parameter bit RESET_MID = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                word_valid,
    input logic [23:0]         word_in,
    input logic [RES_BITS-1:0] dac_code,
    input logic                powered_down
);

    localparam logic [RES_BITS-1:0] RST_CODE =
        RESET_MID ? {1'b1, {(RES_BITS-1){1'b0}}} : '0;

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (dac_code == RST_CODE) && !powered_down);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> $stable(dac_code) && $stable(powered_down));

    assert_stage_keeps_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_in[23:20] == 4'b0000) |=> $stable(dac_code) && $stable(powered_down));

    assert_stage_commit_new_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_in[23:20] == 4'b0011) |=> dac_code == $past(word_in[15 -: RES_BITS]));

    assert_commit_wakes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && (word_in[23:20] == 4'b0001 || word_in[23:20] == 4'b0011)) |=> !powered_down);

    assert_sleep_keeps_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_in[23:20] == 4'b0100) |=> powered_down && $stable(dac_code));

    assert_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_in[23:20] != 4'b0000 && word_in[23:20] != 4'b0001 &&
         word_in[23:20] != 4'b0011 && word_in[23:20] != 4'b0100)
        |=> $stable(dac_code) && $stable(powered_down));

endmodule

bind dac_cmd_regs dac_cmd_regs_chk #(.RES_BITS(RES_BITS), .RESET_MID(RESET_MID)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_valid   (word_valid),
    .word_in      (word_in),
    .dac_code     (dac_code),
    .powered_down (powered_down)
);

// File: tb/dac_cmd_regs_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random command words.
module dac_cmd_regs_tb_top;

    localparam int RES_BITS  = 12;
    localparam bit RESET_MID = 1'b1;
    localparam logic [RES_BITS-1:0] RST_CODE = RESET_MID ? {1'b1, {(RES_BITS-1){1'b0}}} : '0;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                word_valid = 1'b0;
    logic [23:0]         word_in = '0;
    logic [RES_BITS-1:0] dac_code;
    logic                powered_down;

    int checks = 0;
    int failures = 0;

    logic [RES_BITS-1:0] m_stage, m_out;
    logic                m_pd;

    always #5 clk = ~clk;

    dac_cmd_regs #(.RES_BITS(RES_BITS), .RESET_MID(RESET_MID)) dut_i (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
        .dac_code(dac_code), .powered_down(powered_down)
    );

    function automatic logic [23:0] mk(input logic [3:0] c, input logic [3:0] junk,
                                       input logic [RES_BITS-1:0] code, input logic [15:0] low);
        logic [15:0] f;
        f = low;
        f[15 -: RES_BITS] = code;
        return {c, junk, f};
    endfunction

    // Reference model per R2..R10.
    task automatic model(input logic v, input logic [23:0] w);
        logic [RES_BITS-1:0] nc;
        nc = w[15 -: RES_BITS];
        if (v) begin
            case (w[23:20])
                4'b0000: m_stage = nc;
                4'b0001: begin m_out = m_stage; m_pd = 1'b0; end
                4'b0011: begin m_stage = nc; m_out = nc; m_pd = 1'b0; end
                4'b0100: m_pd = 1'b1;
                default: ;
            endcase
        end
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one word at a negedge, let one posedge pass, then compare at the next negedge (R11).
    task automatic step(input string req, input logic v, input logic [23:0] w);
        word_valid = v;
        word_in = w;
        @(negedge clk);
        model(v, w);
        word_valid = 1'b0;
        check(req, 16'(dac_code), 16'(m_out));
        check(req, 16'(powered_down), 16'(m_pd));
    endtask

    initial begin
        #2_000_000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        m_stage = RST_CODE; m_out = RST_CODE; m_pd = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 code", 16'(dac_code), 16'(RST_CODE));
        check("R1 pd", 16'(powered_down), 16'h0);
        rst_n = 1'b1;
        // R4: staging write does not move the output
        step("R4", 1'b1, mk(4'b0000, 4'h0, 12'h123, 16'h0));
        // R5: commit shows the staged code
        step("R5", 1'b1, mk(4'b0001, 4'h0, 12'hFFF, 16'h0));
        // R6: combined command uses the new code
        step("R4", 1'b1, mk(4'b0000, 4'h0, 12'h555, 16'h0));
        step("R6", 1'b1, mk(4'b0011, 4'h0, 12'hABC, 16'h0));
        check("R6 direct", 16'(dac_code), 16'h0ABC);
        // R8: sleep keeps codes, then R7: commit wakes with preserved staging
        step("R4", 1'b1, mk(4'b0000, 4'h0, 12'h777, 16'h0));
        step("R8", 1'b1, mk(4'b0100, 4'h0, 12'h000, 16'h0));
        check("R8 pd", 16'(powered_down), 16'h1);
        step("R10", 1'b0, mk(4'b0001, 4'h0, 12'h000, 16'h0));
        step("R7", 1'b1, mk(4'b0001, 4'h0, 12'h000, 16'h0));
        check("R7 preserved", 16'(dac_code), 16'h0777);
        // R7 via combined command
        step("R8", 1'b1, mk(4'b0100, 4'h0, 12'h000, 16'h0));
        step("R7", 1'b1, mk(4'b0011, 4'h0, 12'h321, 16'h0));
        // R2 / R3: ignored bits set, output must equal clean code
        step("R2 R3", 1'b1, mk(4'b0011, 4'hF, 12'h9A5, 16'h000F));
        check("R3 low bits", 16'(dac_code), 16'h09A5);
        // R9: every undefined code is a no-op
        for (int c = 0; c < 16; c++) begin
            if (c != 0 && c != 1 && c != 3 && c != 4)
                step("R9", 1'b1, mk(4'(c), 4'h0, 12'h0F0, 16'h0));
        end
        // R11: latency - output has not moved before the edge
        word_valid = 1'b1;
        word_in = mk(4'b0011, 4'h0, 12'h246, 16'h0);
        #1 check("R11 before edge", 16'(dac_code), 16'(m_out));
        step("R11", 1'b1, mk(4'b0011, 4'h0, 12'h246, 16'h0));
        // Random mix
        for (int i = 0; i < 2000; i++) begin
            logic [3:0] c;
            logic [23:0] w;
            case ($urandom_range(0, 5))
                0: c = 4'b0000;
                1: c = 4'b0001;
                2: c = 4'b0011;
                3: c = 4'b0100;
                default: c = 4'($urandom_range(0, 15));
            endcase
            w = {c, 20'($urandom)};
            step("R10 random", ($urandom_range(0, 3) != 0), w);
        end
        // R1 again: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 rerun code", 16'(dac_code), 16'(RST_CODE));
        check("R1 rerun pd", 16'(powered_down), 16'h0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule